// File: doc/BRIEF.md
# BCD Calendar Alarm Unit

This block holds a four-field alarm (seconds, minutes, hours, day of month) and compares it with the calendar time that an external timekeeping counter supplies in BCD. It compares only when that counter strobes that a second has elapsed. When the fields chosen by the alarm's mask bits agree with the time, the block emits a single-cycle interrupt pulse. Each alarm byte carries a mask flag in its top bit. The combination of these flags sets how often the alarm repeats: every month, day, hour, minute or second.

Software programs the alarm through a byte-wide register port. Writes are checked for range, and a write whose BCD value lies outside the field's legal range is dropped without effect. Reads return the stored bytes exactly as written.

Top module: `bcd_alarm_unit`

## Requirements
- R1: Four alarm bytes sit at register addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (day of month). `reg_rdata` shows the stored byte at `reg_addr` combinationally, including its bit 7.
- R2: While `rst_n` is low, all four alarm bytes read 0x00 and `alarm_irq` is low.
- R3: A write to seconds or minutes is accepted only when the decimal value (bits 6:4 as tens, bits 3:0 as units, tens*10+units) is between 0 and 59. A rejected write leaves the byte unchanged.
- R4: A write to hours is accepted only when the decimal value of bits 5:0 (bits 5:4 tens, bits 3:0 units) is between 0 and 23. Otherwise the byte is unchanged.
- R5: A write to day of month is accepted only when the decimal value of bits 4:0 (bit 4 tens, bits 3:0 units) is not zero. Otherwise the byte is unchanged.
- R6: An accepted write stores all eight bits, including the mask bit 7, and is visible on the cycle after the write edge.
- R7: With all four mask bits clear, a tick fires the alarm when seconds and minutes match on bits 6:0 and hours and day match on bits 5:0.
- R8: With only the day mask set, a tick fires when hours, minutes and seconds match.
- R9: With the day and hour masks set and the others clear, a tick fires when minutes and seconds match.
- R10: With the day, hour and minute masks set and the seconds mask clear, a tick fires when seconds match.
- R11: Any other mask combination fires the alarm on every tick.
- R12: `alarm_irq` is high for exactly the one cycle after a firing `sec_tick` cycle. It is never high except after a tick.
- R13: When a write and a tick fall in the same cycle, the comparison uses the alarm bytes held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Alarm register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sec_tick | input | 1 | One-cycle strobe: the time has advanced by one second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| alarm_irq | output | 1 | Single-cycle alarm pulse |

## Verification
Two situations are hard to reach: the irregular mask patterns that fall back to firing every second, and a write that lands in the same cycle as a tick. A real time source would need a month of ticks to exercise the monthly match. The bench avoids this by driving the time inputs directly, so it can present a matching or a single-field mismatching time on any chosen tick. It steps the mask bits through every ordered pattern and through sparse ones, such as only the seconds mask set. It also issues a write together with a tick, and its cycle-level model predicts which alarm value that tick must use.

// File: rtl/bcd_alarm_pkg.sv
`timescale 1ns/1ps
package bcd_alarm_pkg;
    localparam int FIELD_COUNT = 4;
    localparam int BYTE_W      = 8;
    localparam int IDX_W       = $clog2(FIELD_COUNT);
    localparam int MASK_BIT    = BYTE_W - 1;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MIN,
        RATE_SEC
    } rate_e;

    // bits of a write that carry the value checked for range
    function automatic byte_t wr_value_mask(input int f);
        case (f)
            F_SEC, F_MIN: return 8'h7F;
            F_HOUR:       return 8'h3F;
            default:      return 8'h1F;
        endcase
    endfunction

    // bits compared against the running time
    function automatic byte_t cmp_mask(input int f);
        case (f)
            F_SEC, F_MIN: return 8'h7F;
            default:      return 8'h3F;
        endcase
    endfunction

    function automatic int range_lo(input int f);
        return (f == F_DATE) ? 1 : 0;
    endfunction

    function automatic int range_hi(input int f);
        case (f)
            F_SEC, F_MIN: return 59;
            F_HOUR:       return 23;
            default:      return 255;
        endcase
    endfunction
endpackage

// File: rtl/alarm_wr_filter.sv
`timescale 1ns/1ps
module alarm_wr_filter
    import bcd_alarm_pkg::*;
#(
    parameter int FIELD = F_SEC
) (
    input  byte_t wdata,
    output logic  accept
);
    localparam byte_t VMASK = wr_value_mask(FIELD);
    localparam int    LO    = range_lo(FIELD);
    localparam int    HI    = range_hi(FIELD);
    localparam byte_t LO_B  = byte_t'(LO);
    localparam byte_t HI_B  = byte_t'((HI > 255) ? 255 : HI);

    byte_t v;
    byte_t dec;

    always_comb begin
        v   = wdata & VMASK;
        dec = v[7:4] * 8'd10 + {4'd0, v[3:0]};
    end

    generate
        if (LO == 0) begin : g_lo_zero
            assign accept = (dec <= HI_B);
        end else if (HI >= 255) begin : g_no_hi
            assign accept = (dec >= LO_B);
        end else begin : g_window
            assign accept = (dec >= LO_B) && (dec <= HI_B);
        end
    endgenerate
endmodule

// File: rtl/alarm_match_logic.sv
`timescale 1ns/1ps
module alarm_match_logic
    import bcd_alarm_pkg::*;
(
    input  logic [FIELD_COUNT-1:0][BYTE_W-1:0] alm,
    input  logic [FIELD_COUNT-1:0][BYTE_W-1:0] now,
    output logic                               hit
);
    logic [FIELD_COUNT-1:0] eq;
    logic [FIELD_COUNT-1:0] msk;
    rate_e                  rate;

    genvar f;
    generate
        for (f = 0; f < FIELD_COUNT; f++) begin : g_field
            localparam byte_t CM = cmp_mask(f);
            assign eq[f]  = (((alm[f] ^ now[f]) & CM) == '0);
            assign msk[f] = alm[f][MASK_BIT];
        end
    endgenerate

    // fixed priority pattern of mask flags picks the repeat period
    always_comb begin
        case ({msk[F_DATE], msk[F_HOUR], msk[F_MIN], msk[F_SEC]})
            4'b0000: rate = RATE_MONTH;
            4'b1000: rate = RATE_DAY;
            4'b1100: rate = RATE_HOUR;
            4'b1110: rate = RATE_MIN;
            default: rate = RATE_SEC;
        endcase
    end

    always_comb begin
        case (rate)
            RATE_MONTH: hit = &eq;
            RATE_DAY:   hit = eq[F_HOUR] & eq[F_MIN] & eq[F_SEC];
            RATE_HOUR:  hit = eq[F_MIN] & eq[F_SEC];
            RATE_MIN:   hit = eq[F_SEC];
            default:    hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcd_alarm_unit.sv
`timescale 1ns/1ps
module bcd_alarm_unit
    import bcd_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              sec_tick,
    input  logic [BYTE_W-1:0] now_sec,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_date,
    output logic              alarm_irq
);
    typedef struct packed {
        logic [FIELD_COUNT-1:0][BYTE_W-1:0] alm;
        logic                               irq;
    } state_t;

    state_t st_d, st_q;

    logic [FIELD_COUNT-1:0]             accept;
    logic [FIELD_COUNT-1:0][BYTE_W-1:0] now_vec;
    logic                               hit;
    logic [FIELD_COUNT*BYTE_W-1:0]      alm_view;

    always_comb begin
        now_vec[F_SEC]  = now_sec;
        now_vec[F_MIN]  = now_min;
        now_vec[F_HOUR] = now_hour;
        now_vec[F_DATE] = now_date;
    end

    genvar f;
    generate
        for (f = 0; f < FIELD_COUNT; f++) begin : g_filt
            alarm_wr_filter #(.FIELD(f)) u_filt (
                .wdata  (reg_wdata),
                .accept (accept[f])
            );
        end
    endgenerate

    alarm_match_logic u_match (
        .alm (st_q.alm),
        .now (now_vec),
        .hit (hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = sec_tick & hit;
        if (reg_we && accept[reg_addr]) begin
            st_d.alm[reg_addr] = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.alm[reg_addr];
    assign alarm_irq = st_q.irq;
    assign alm_view  = st_q.alm;
endmodule

// File: rtl/bcd_alarm_unit_checker.sv
`timescale 1ns/1ps
module bcd_alarm_unit_checker
    import bcd_alarm_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_we,
    input logic [IDX_W-1:0]              reg_addr,
    input logic [BYTE_W-1:0]             reg_rdata,
    input logic                          sec_tick,
    input logic [BYTE_W-1:0]             now_date,
    input logic                          alarm_irq,
    input logic [FIELD_COUNT*BYTE_W-1:0] alm_bits
);
    logic [FIELD_COUNT-1:0] mk;
    logic [5:0]             alm_date_cmp;

    genvar f;
    generate
        for (f = 0; f < FIELD_COUNT; f++) begin : g_mk
            assign mk[f] = alm_bits[f*BYTE_W + MASK_BIT];
        end
    endgenerate
    assign alm_date_cmp = alm_bits[F_DATE*BYTE_W +: 6];

    logic [3:0] pat;
    assign pat = {mk[F_DATE], mk[F_HOUR], mk[F_MIN], mk[F_SEC]};

    a_r12_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(sec_tick));

    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !alarm_irq);

    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_we) && $stable(reg_addr)) |-> $stable(reg_rdata));

    a_r11_fallback_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && pat != 4'b0000 && pat != 4'b1000 && pat != 4'b1100 && pat != 4'b1110)
        |=> alarm_irq);

    a_r7_month_date_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && pat == 4'b0000 && now_date[5:0] != alm_date_cmp) |=> !alarm_irq);
endmodule

bind bcd_alarm_unit bcd_alarm_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .sec_tick  (sec_tick),
    .now_date  (now_date),
    .alarm_irq (alarm_irq),
    .alm_bits  (alm_view)
);

// File: tb/bcd_alarm_unit_bench.sv
`timescale 1ns/1ps
module bcd_alarm_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = 8'h01;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_alm[4];

    always #10 clk = ~clk;

    bcd_alarm_unit u_bcd_alarm_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .alarm_irq(alarm_irq)
    );

    function automatic int decval(input int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    function automatic bit m_accept(input int f, input int w);
        case (f)
            0, 1:    return decval(w & 'h7F) <= 59;
            2:       return decval(w & 'h3F) <= 23;
            default: return decval(w & 'h1F) != 0;
        endcase
    endfunction

    function automatic bit m_hit(input int s, input int mi, input int h, input int d);
        bit es, em, eh, ed;
        es = ((m_alm[0] ^ s)  & 'h7F) == 0;
        em = ((m_alm[1] ^ mi) & 'h7F) == 0;
        eh = ((m_alm[2] ^ h)  & 'h3F) == 0;
        ed = ((m_alm[3] ^ d)  & 'h3F) == 0;
        if (m_alm[3] < 128 && m_alm[2] < 128 && m_alm[1] < 128 && m_alm[0] < 128)
            return es && em && eh && ed;
        if (m_alm[3] >= 128 && m_alm[2] < 128 && m_alm[1] < 128 && m_alm[0] < 128)
            return es && em && eh;
        if (m_alm[3] >= 128 && m_alm[2] >= 128 && m_alm[1] < 128 && m_alm[0] < 128)
            return es && em;
        if (m_alm[3] >= 128 && m_alm[2] >= 128 && m_alm[1] >= 128 && m_alm[0] < 128)
            return es;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, let the edge pass, update the model, compare
    task automatic cyc(input string tag, input bit we, input int addr, input int wd,
                       input bit tk, input int s, input int mi, input int h, input int d);
        bit exp_irq;
        @(negedge clk);
        reg_we = we; reg_addr = 2'(addr); reg_wdata = 8'(wd); sec_tick = tk;
        now_sec = 8'(s); now_min = 8'(mi); now_hour = 8'(h); now_date = 8'(d);
        @(posedge clk);
        exp_irq = tk && m_hit(s, mi, h, d);
        if (we && m_accept(addr, wd)) m_alm[addr] = wd;
        #5;
        chk(tag, "irq", int'(alarm_irq), int'(exp_irq));
        chk(tag, "rdata", int'(reg_rdata), m_alm[addr]);
    endtask

    task automatic wr(input string tag, input int addr, input int wd);
        cyc(tag, 1, addr, wd, 0, 0, 0, 0, 1);
    endtask

    task automatic idle(input string tag, input int addr);
        cyc(tag, 0, addr, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic tick(input string tag, input int s, input int mi, input int h, input int d);
        cyc(tag, 0, 0, 0, 1, s, mi, h, d);
        idle(tag, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_alm[i] = 0;
        // R2 / R1: reset state
        repeat (3) @(posedge clk);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            reg_addr = 2'(a); reg_we = 1'b1; reg_wdata = 8'h11;
            #2;
            chk("R2", "reset rdata", int'(reg_rdata), 0);
            chk("R2", "reset irq", int'(alarm_irq), 0);
        end
        @(negedge clk);
        reg_we = 1'b0;
        rst_n = 1'b1;

        // R3: seconds and minutes range
        wr("R3", 0, 'h59);
        wr("R3", 0, 'h60);
        wr("R3", 0, 'h7A);
        wr("R6", 0, 'hC5);
        wr("R3", 1, 'h5A);
        wr("R3", 1, 'h59);
        // R4: hours range
        wr("R4", 2, 'h24);
        wr("R4", 2, 'h23);
        wr("R6", 2, 'hA1);
        wr("R4", 2, 'hBF);
        // R5: day range
        wr("R5", 3, 'h00);
        wr("R5", 3, 'h20);
        wr("R5", 3, 'h80);
        wr("R5", 3, 'h31);
        for (int a = 0; a < 4; a++) idle("R1", a);

        // R7: monthly, all masks clear
        wr("R7", 0, 'h30); wr("R7", 1, 'h15); wr("R7", 2, 'h12); wr("R7", 3, 'h25);
        tick("R7", 'h30, 'h15, 'h12, 'h25);
        tick("R7", 'h30, 'h15, 'h12, 'h24);
        tick("R7", 'h31, 'h15, 'h12, 'h25);
        cyc("R12", 0, 0, 0, 0, 'h30, 'h15, 'h12, 'h25);
        // R12: back-to-back ticks with a match each time
        cyc("R12", 0, 0, 0, 1, 'h30, 'h15, 'h12, 'h25);
        cyc("R12", 0, 0, 0, 1, 'h30, 'h15, 'h12, 'h25);
        idle("R12", 0);

        // R8: daily
        wr("R8", 3, 'h85);
        tick("R8", 'h30, 'h15, 'h12, 'h03);
        tick("R8", 'h30, 'h15, 'h11, 'h03);
        // R9: hourly
        wr("R9", 2, 'h92);
        tick("R9", 'h30, 'h15, 'h07, 'h09);
        tick("R9", 'h30, 'h16, 'h07, 'h09);
        // R10: once a minute
        wr("R10", 1, 'h95);
        tick("R10", 'h30, 'h44, 'h07, 'h09);
        tick("R10", 'h29, 'h44, 'h07, 'h09);
        // R11: all masks set
        wr("R11", 0, 'hB0);
        tick("R11", 'h01, 'h02, 'h03, 'h04);
        // R11: only seconds mask set
        wr("R11", 1, 'h15); wr("R11", 2, 'h12); wr("R11", 3, 'h25);
        tick("R11", 'h01, 'h02, 'h03, 'h04);
        // R11: only hour mask set
        wr("R11", 0, 'h30); wr("R11", 2, 'h92);
        tick("R11", 'h01, 'h02, 'h03, 'h04);

        // R13: write during a tick, monthly mode
        wr("R13", 2, 'h12);
        cyc("R13", 1, 0, 'h45, 1, 'h30, 'h15, 'h12, 'h25);
        idle("R13", 0);
        tick("R13", 'h30, 'h15, 'h12, 'h25);
        tick("R13", 'h45, 'h15, 'h12, 'h25);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule